// File: doc/BRIEF.md
# Read-Addressed Cartridge Mode Selector

This block picks the operating mode of a cartridge by watching the halfword reads that the host makes. The host cannot rely on writes for this, so it issues a fixed run of ten reads. One read in that run carries a mode word, encoded in its address. The block compares each read strobe and byte address against the run. When the run completes with a recognised mode word, the block switches its mode output to ROM, media, RAM read-only or RAM read-write.

After a switch into ROM mode, a short follow-up pattern of four reads opens ROM offsets from 0x200 upward. Until that region is opened, a ROM-window read at such an offset is not served. A single halfword write of a fixed key to a fixed address offers a second way into RAM read-write mode. Returning data and driving the media interface are handled elsewhere. This block only produces the mode, the open flag and a per-read ROM-serve qualifier.

Top module: `cart_mode_seq`

## Requirements
- R1: After reset, mode is ROM (code 0), the upper-ROM open flag is 0, and the matcher waits for its first step.
- R2: Ten reads complete the signature. Reads 1 to 7 are at 0x08E00002, 0x0800000E, 0x08801FFC, 0x0800104A, 0x08800612, 0x08000000 and 0x08801B66. Read 8 is at 0x08000000 plus twice the mode word. Reads 9 and 10 are at 0x0800080E and then 0x08000000. Mode word low nibble 4 gives mode code 0 (ROM), 3 gives 1 (media), 2 gives 2 (RAM read-only) and 6 gives 3 (RAM read-write).
- R3: The mode output changes only on the clock edge that samples the tenth read. After nine reads it still holds the old value.
- R4: A read that does not match the expected step returns the matcher to its first step and leaves the mode unchanged. If that read is at the first address, it counts as step one of a new run.
- R5: Cycles with neither strobe asserted change no state, including inside a run.
- R6: A completed run whose mode word low nibble is not 2, 3, 4 or 6 leaves the mode and the open flag unchanged.
- R7: A switch to ROM arms the unlock. The next four reads at 0x080001E4, 0x080001E4, 0x08000188 and 0x08000188 then set the open flag. Any other read before that disarms it.
- R8: A completed switch to any valid mode clears the open flag. The open flag is set only while the mode is ROM.
- R9: A halfword write of 0xAA55 to 0x09FFEFFE sets the mode to RAM read-write and clears the open flag and the unlock arming. Any other write has no effect.
- R10: rom_ok is high during a read exactly when mode is ROM, the address lies in 0x08000000..0x09FFFFFF, and either the offset within that window is below 0x200 or the open flag is set.
- R11: Read 8 matches any even address in 0x08000000..0x09FFFFFF, and bits 4:1 of that address form the mode nibble. An odd address at read 8 breaks the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Halfword read strobe, one cycle per read |
| wr_en | input | 1 | Halfword write strobe |
| addr | input | 32 | Byte address of the access |
| wdata | input | 16 | Write data |
| mode | output | 2 | 0 ROM, 1 media, 2 RAM read-only, 3 RAM read-write |
| hi_open | output | 1 | ROM offsets at or above 0x200 are open |
| rom_ok | output | 1 | The current read may be served from ROM |

## Verification
The hardest situation to reach from the ports is an armed unlock that is broken or completed at one exact step. It needs a full ten-read run ending in ROM first, followed by a precise read pattern. Breaks partway through the long signature are similarly rare under pure random addresses. The random stimulus therefore draws its reads mostly from the signature and unlock address pool, and it often injects whole runs with random mode words. Directed cases then break the run at step 8 with an odd address and break the unlock after its second read.

// File: rtl/cart_mode_seq.sv
module cart_mode_seq #(
  parameter logic [24:0] OPEN_BASE = 25'h200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [31:0] addr,
  input  logic [15:0] wdata,
  output logic [1:0]  mode,
  output logic        hi_open,
  output logic        rom_ok
);
  localparam logic [3:0]  LAST_STEP = 4'd9;
  localparam logic [31:0] WR_KEY_ADDR = 32'h09FF_EFFE;
  localparam logic [15:0] WR_KEY_DATA = 16'hAA55;
  localparam logic [1:0]  M_ROM = 2'd0, M_MEDIA = 2'd1, M_RAM_RO = 2'd2, M_RAM_RW = 2'd3;

  logic [3:0] step;
  logic [3:0] nib;
  logic [1:0] ustep;
  logic       arm;
  logic       in_win, sig_hit, ulk_hit, wr_hit, dec_ok;
  logic [1:0] dec_mode;
  logic [31:0] step_addr;

  always_comb begin
    case (step)
      4'd0: step_addr = 32'h08E0_0002;
      4'd1: step_addr = 32'h0800_000E;
      4'd2: step_addr = 32'h0880_1FFC;
      4'd3: step_addr = 32'h0800_104A;
      4'd4: step_addr = 32'h0880_0612;
      4'd5: step_addr = 32'h0800_0000;
      4'd6: step_addr = 32'h0880_1B66;
      4'd8: step_addr = 32'h0800_080E;
      default: step_addr = 32'h0800_0000;
    endcase
  end

  always_comb begin
    dec_ok = 1'b1;
    case (nib)
      4'h4: dec_mode = M_ROM;
      4'h3: dec_mode = M_MEDIA;
      4'h2: dec_mode = M_RAM_RO;
      4'h6: dec_mode = M_RAM_RW;
      default: begin dec_mode = mode; dec_ok = 1'b0; end
    endcase
  end

  assign in_win  = addr[31:25] == 7'd4;
  assign sig_hit = (step == 4'd7) ? (in_win && !addr[0]) : (addr == step_addr);
  assign ulk_hit = addr == (ustep[1] ? 32'h0800_0188 : 32'h0800_01E4);
  assign wr_hit  = wr_en && addr == WR_KEY_ADDR && wdata == WR_KEY_DATA;
  assign rom_ok  = rd_en && mode == M_ROM && in_win && (addr[24:0] < OPEN_BASE || hi_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0; nib <= '0; ustep <= '0; arm <= 1'b0;
      mode <= M_ROM; hi_open <= 1'b0;
    end else begin
      if (rd_en) begin
        if (arm) begin
          if (ulk_hit) begin
            if (ustep == 2'd3) begin hi_open <= 1'b1; arm <= 1'b0; ustep <= '0; end
            else ustep <= ustep + 2'd1;
          end else begin
            arm <= 1'b0; ustep <= '0;
          end
        end
        if (sig_hit) begin
          if (step == 4'd7) nib <= addr[4:1];
          if (step == LAST_STEP) begin
            step <= '0;
            if (dec_ok) begin
              mode <= dec_mode; hi_open <= 1'b0;
              arm <= dec_mode == M_ROM; ustep <= '0;
            end
          end else step <= step + 4'd1;
        end else begin
          step <= (addr == 32'h08E0_0002) ? 4'd1 : 4'd0;
        end
      end
      if (wr_hit) begin
        mode <= M_RAM_RW; hi_open <= 1'b0; arm <= 1'b0; ustep <= '0;
      end
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) step <= LAST_STEP); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> ($stable(mode) && $stable(hi_open))); // R5
  AST_MODE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(wr_en) || ($past(rd_en) && $past(addr) == 32'h0800_0000))); // R3
  AST_OPEN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_open) |-> ($past(rd_en) && $past(addr) == 32'h0800_0188)); // R7
  AST_OPEN_IN_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    hi_open |-> mode == M_ROM); // R8
  AST_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == WR_KEY_ADDR && wdata == WR_KEY_DATA) |=> (mode == M_RAM_RW && !hi_open)); // R9
endmodule

// File: tb/sim_cart_mode_seq.sv
module sim_cart_mode_seq;
  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0] mode;
  logic hi_open, rom_ok;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  int m_step, m_nib, m_ustep, m_mode;
  bit m_arm, m_open;

  always #2 clk = ~clk;

  cart_mode_seq u0 (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .mode(mode), .hi_open(hi_open), .rom_ok(rom_ok));

  function automatic logic [31:0] sig(int i, logic [23:0] word);
    case (i)
      0: return 32'h08E0_0002;
      1: return 32'h0800_000E;
      2: return 32'h0880_1FFC;
      3: return 32'h0800_104A;
      4: return 32'h0880_0612;
      5: return 32'h0800_0000;
      6: return 32'h0880_1B66;
      7: return 32'h0800_0000 + {7'd0, word, 1'b0};
      8: return 32'h0800_080E;
      default: return 32'h0800_0000;
    endcase
  endfunction

  function automatic int map_nib(int n);
    case (n)
      4: return 0;
      3: return 1;
      2: return 2;
      6: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(bit rd, bit wr, logic [31:0] a, logic [15:0] d);
    bit hit;
    if (rd) begin
      if (m_arm) begin
        if (a == (m_ustep >= 2 ? 32'h0800_0188 : 32'h0800_01E4)) begin
          m_ustep++;
          if (m_ustep == 4) begin m_open = 1; m_arm = 0; m_ustep = 0; end
        end else begin m_arm = 0; m_ustep = 0; end
      end
      hit = (m_step == 7) ? (a[31:25] == 7'd4 && !a[0]) : (a == sig(m_step, '0));
      if (hit) begin
        if (m_step == 7) m_nib = int'(a[4:1]);
        if (m_step == 9) begin
          m_step = 0;
          if (map_nib(m_nib) >= 0) begin
            m_mode = map_nib(m_nib); m_open = 0; m_arm = (m_mode == 0); m_ustep = 0;
          end
        end else m_step++;
      end else m_step = (a == 32'h08E0_0002) ? 1 : 0;
    end
    if (wr && a == 32'h09FF_EFFE && d == 16'hAA55) begin
      m_mode = 3; m_open = 0; m_arm = 0; m_ustep = 0;
    end
  endtask

  task automatic op(bit rd, bit wr, logic [31:0] a, logic [15:0] d, string tag);
    bit exp_ok;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = d;
    #1;
    exp_ok = rd && m_mode == 0 && a[31:25] == 7'd4 && (a[24:0] < 25'h200 || m_open);
    chk("R10 rom_ok", int'(rom_ok), int'(exp_ok));
    @(posedge clk); #1;
    rd_en = 0; wr_en = 0;
    model(rd, wr, a, d);
    chk({tag, " mode"}, int'(mode), m_mode);
    chk({tag, " hi_open"}, int'(hi_open), int'(m_open));
  endtask

  task automatic rd(logic [31:0] a, string tag);
    op(1, 0, a, '0, tag);
  endtask

  task automatic run_sig(logic [23:0] word, string tag);
    for (int i = 0; i < 10; i++) rd(sig(i, word), tag);
  endtask

  task automatic unlock(string tag);
    rd(32'h0800_01E4, tag); rd(32'h0800_01E4, tag);
    rd(32'h0800_0188, tag); rd(32'h0800_0188, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_step = 0; m_nib = 0; m_ustep = 0; m_mode = 0; m_arm = 0; m_open = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset hi_open", int'(hi_open), 0);

    rd(32'h0800_0200, "R10 locked");
    rd(32'h0800_01FE, "R10 low");

    for (int i = 0; i < 9; i++) rd(sig(i, 24'h40_0003), "R3 partial");
    chk("R3 nine reads", int'(mode), 0);
    rd(sig(9, 0), "R2 media");
    chk("R2 media code", int'(mode), 1);

    run_sig(24'h40_0004, "R2 rom");
    chk("R2 rom code", int'(mode), 0);
    unlock("R7 unlock");
    chk("R7 open set", int'(hi_open), 1);
    rd(32'h0900_0000, "R10 opened");

    run_sig(24'h40_0002, "R8 ramro");
    chk("R8 cleared", int'(hi_open), 0);
    chk("R2 ramro code", int'(mode), 2);

    for (int i = 0; i < 10; i++) begin
      rd(sig(i, 24'h40_0006), "R5 gaps");
      repeat (2) @(negedge clk);
    end
    chk("R5 ramrw code", int'(mode), 3);

    for (int i = 0; i < 5; i++) rd(sig(i, 0), "R4 partial");
    rd(32'h0800_1234, "R4 break");
    for (int i = 5; i < 10; i++) rd(sig(i, 24'h40_0004), "R4 tail");
    chk("R4 unchanged", int'(mode), 3);
    for (int i = 0; i < 3; i++) rd(sig(i, 0), "R4 partial2");
    run_sig(24'h40_0003, "R4 restart");
    chk("R4 restart code", int'(mode), 1);

    run_sig(24'h00_0005, "R6 bad nibble");
    chk("R6 unchanged", int'(mode), 1);

    for (int i = 0; i < 7; i++) rd(sig(i, 0), "R11 pre");
    rd(32'h0800_0009, "R11 odd");
    rd(sig(8, 0), "R11 after");
    rd(sig(9, 0), "R11 after");
    chk("R11 odd breaks", int'(mode), 1);
    run_sig(24'hFF_FFF4, "R11 high word");
    chk("R11 high word rom", int'(mode), 0);

    rd(32'h0800_01E4, "R7 part"); rd(32'h0800_01E4, "R7 part");
    rd(32'h0800_0100, "R7 breaker");
    rd(32'h0800_0188, "R7 late"); rd(32'h0800_0188, "R7 late");
    chk("R7 disarmed", int'(hi_open), 0);

    op(0, 1, 32'h09FF_EFFE, 16'hAA54, "R9 wrong data");
    chk("R9 wrong data", int'(mode), 0);
    op(0, 1, 32'h09FF_EFFC, 16'hAA55, "R9 wrong addr");
    op(0, 1, 32'h09FF_EFFE, 16'hAA55, "R9 key");
    chk("R9 ramrw", int'(mode), 3);

    for (int n = 0; n < 3000; n++) begin
      int pick = int'($urandom % 10);
      if (pick < 2) begin
        run_sig($urandom % 24'hFF_FFFF, "R2 random run");
        if ($urandom % 2) unlock("R7 random unlock");
      end else if (pick < 8) begin
        int k = int'($urandom % 14);
        logic [31:0] a;
        if (k < 10) a = sig(k, 24'($urandom));
        else if (k == 10) a = 32'h0800_01E4;
        else if (k == 11) a = 32'h0800_0188;
        else a = 32'h0800_0000 | ($urandom & 32'h01FF_FFFE);
        rd(a, "R4 random read");
      end else if (pick == 8) begin
        op(0, 1, ($urandom % 2) ? 32'h09FF_EFFE : $urandom, ($urandom % 2) ? 16'hAA55 : 16'($urandom), "R9 random write");
      end else begin
        @(negedge clk);
        chk("R5 idle mode", int'(mode), m_mode);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule